// File: doc/BRIEF.md
# Memory Protection Controller Access Filter

This block stands between one bus requester and a memory and checks every transfer against a per-block security map. The protected address range is cut into equal blocks whose size is a power of two. A lookup table holds one bit per block; a set bit marks the block as non-secure. A transfer is forwarded to the memory only when its non-secure attribute equals the bit of the block it hits. Any other transfer is blocked and never reaches the memory.

Software picks how a blocked transfer is answered. In one mode reads return zero and writes are dropped. In the other mode the requester gets a bus error. The first blocked transfer sets an interrupt status flag and records the failing address and requester details. Later blocked transfers leave that record alone until software clears the flag. The interrupt line is the status flag gated by an enable bit. A small register port holds the mode bit, the enable bit, the status, the set and clear controls, the two fault records and the lookup table.

Transfers are single-cycle. The filter decision and the response are combinational from the request and the current table. Register writes and fault capture take effect at the next rising clock edge.

Top module: `mpc_filter`

## Requirements
- R1: The block number is `req_addr >> BLK_SHIFT`. Its table bit is bit (block mod 32) of table word (block / 32). Table word `w` is at register offset `0x100 + 4*w`, is written whole, and reads back what was written. A set bit marks the block as non-secure.
- R2: When `req_valid` is high and `req_nonsec` equals the block's table bit, the filter drives `mem_valid` high in the same cycle. `mem_addr`, `mem_write` and `mem_wdata` copy the request, `rsp_rdata` equals `mem_rdata`, and `rsp_err` is 0.
- R3: When `req_valid` is high and `req_nonsec` differs from the block's table bit, the transfer is blocked and `mem_valid` stays 0 in that cycle.
- R4: When bit 0 of the control register (offset 0x000) is 0, a blocked transfer gives `rsp_rdata` = 0 and `rsp_err` = 0, and a blocked write changes nothing downstream.
- R5: When control bit 0 is 1, a blocked transfer gives `rsp_err` = 1 and `rsp_rdata` = 0 in the same cycle.
- R6: A blocked transfer while the status (offset 0x020, bit 0) is 0 sets the status at the next edge. The same edge loads the first info register (offset 0x02C) with the zero-extended address. It loads the second info register (offset 0x030) with the low 16 bits of `req_id` in bits 15:0, `req_nonsec` in bit 16, the block's table bit in bit 17, and zeros above.
- R7: While the status is 1, blocked transfers are still blocked, but neither info register changes.
- R8: Writing 1 to bit 0 of the clear register (offset 0x024) clears the status. The next blocked transfer is captured again as in R6.
- R9: Writing 1 to bit 0 of the set register (offset 0x034) sets the status and leaves both info registers unchanged. In the same cycle, a set or a capture wins over a clear.
- R10: `irq` is high exactly when the status is 1 and bit 0 of the enable register (offset 0x028) is 1.
- R11: After reset, all registers and table words read 0, so every block is secure, the response mode is read-zero and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer byte address |
| req_nonsec | input | 1 | Non-secure attribute of the transfer |
| req_id | input | ID_W | Requester identifier |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data returned to the requester |
| rsp_err | output | 1 | Bus error response |
| mem_valid | output | 1 | Transfer forwarded to memory |
| mem_write | output | 1 | Forwarded direction |
| mem_addr | output | ADDR_W | Forwarded address |
| mem_wdata | output | DATA_W | Forwarded write data |
| mem_rdata | input | DATA_W | Memory read data |
| cfg_en | input | 1 | Register access strobe |
| cfg_write | input | 1 | 1 = register write |
| cfg_addr | input | CFG_AW | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Blocked-transfer interrupt |

## Verification
Directed transfers pair one block with both attribute values. This separates a correct bit lookup from a wrong word or bit index, and forwarding from blocking. The same blocked read and write run once in each response mode, which shows whether the mode bit steers the zero/drop answer and the error answer. A sequence of capture, second violation, clear and new violation, plus a forced set, shows whether the record freezes and re-arms. Seeded random addresses, attributes, IDs and table contents, with clears at random points, compare every response and record against a bench model.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
    localparam logic [11:0] OFS_CTRL   = 12'h000;
    localparam logic [11:0] OFS_STAT   = 12'h020;
    localparam logic [11:0] OFS_CLEAR  = 12'h024;
    localparam logic [11:0] OFS_ENABLE = 12'h028;
    localparam logic [11:0] OFS_INFO_A = 12'h02C;
    localparam logic [11:0] OFS_INFO_B = 12'h030;
    localparam logic [11:0] OFS_SET    = 12'h034;
    localparam logic [11:0] OFS_TABLE  = 12'h100;

    typedef enum logic {
        RESP_ZERO  = 1'b0,
        RESP_ERROR = 1'b1
    } resp_mode_e;

    localparam int INFO_B_W = 18;
endpackage

// File: rtl/mpc_table.sv
module mpc_table #(
    parameter int ADDR_W    = 16,
    parameter int BLK_SHIFT = 8,
    parameter int CFG_AW    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       wr_data,
    output logic              cfg_hit,
    output logic [31:0]       cfg_word,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_bit
);
    import mpc_pkg::*;

    localparam int BLK_W     = ADDR_W - BLK_SHIFT;
    localparam int NUM_BLKS  = 1 << BLK_W;
    localparam int WORDS     = (NUM_BLKS + 31) / 32;
    localparam int WIDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int TABLE_END = int'(OFS_TABLE) + 4 * WORDS;

    typedef struct packed {
        logic [WORDS-1:0][31:0] words;
    } table_t;

    table_t tab_d, tab_q;

    logic [BLK_W-1:0]  blk_num;
    logic [WIDX_W-1:0] look_word;
    logic [4:0]        look_pos;
    logic [WIDX_W-1:0] cfg_idx;

    assign blk_num = look_addr[ADDR_W-1:BLK_SHIFT];

    generate
        if (BLK_W > 5) begin : g_multi_word
            assign look_word = blk_num[BLK_W-1:5];
            assign look_pos  = blk_num[4:0];
        end else begin : g_single_word
            assign look_word = '0;
            assign look_pos  = 5'(blk_num);
        end
    endgenerate

    assign cfg_hit = (int'(cfg_addr) >= int'(OFS_TABLE)) && (int'(cfg_addr) < TABLE_END)
                     && (cfg_addr[1:0] == 2'b00);
    assign cfg_idx = WIDX_W'((int'(cfg_addr) - int'(OFS_TABLE)) >> 2);

    always_comb begin
        tab_d = tab_q;
        if (wr_en && cfg_hit) begin
            for (int w = 0; w < WORDS; w++) begin
                if (cfg_idx == WIDX_W'(w)) tab_d.words[w] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    assign cfg_word = cfg_hit ? tab_q.words[cfg_idx] : 32'h0;
    assign look_bit = tab_q.words[look_word][look_pos];

    // R1: a table write lands in exactly the addressed word
    p_table_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_hit) |=> (tab_q.words[$past(cfg_idx)] == $past(wr_data)));
endmodule

// File: rtl/mpc_status.sv
module mpc_status #(
    parameter int ADDR_W = 16,
    parameter int ID_W   = 20,
    parameter int CFG_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_write,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              viol,
    input  logic [ADDR_W-1:0] viol_addr,
    input  logic              viol_nonsec,
    input  logic [ID_W-1:0]   viol_id,
    input  logic              viol_blk_bit,
    output logic              err_mode,
    output logic              irq
);
    import mpc_pkg::*;

    typedef struct packed {
        resp_mode_e          mode;
        logic                int_en;
        logic                stat;
        logic [ADDR_W-1:0]   info_a;
        logic [INFO_B_W-1:0] info_b;
    } stat_t;

    stat_t st_d, st_q;

    logic        wr_hit;
    logic        clr_req, set_req;
    logic [15:0] id16;

    assign wr_hit = cfg_en && cfg_write;

    generate
        if (ID_W >= 16) begin : g_id_trunc
            assign id16 = viol_id[15:0];
        end else begin : g_id_pad
            assign id16 = {{(16 - ID_W){1'b0}}, viol_id};
        end
    endgenerate

    assign clr_req = wr_hit && (cfg_addr == CFG_AW'(OFS_CLEAR)) && cfg_wdata[0];
    assign set_req = wr_hit && (cfg_addr == CFG_AW'(OFS_SET)) && cfg_wdata[0];

    always_comb begin
        st_d = st_q;
        if (wr_hit && cfg_addr == CFG_AW'(OFS_CTRL))   st_d.mode   = resp_mode_e'(cfg_wdata[0]);
        if (wr_hit && cfg_addr == CFG_AW'(OFS_ENABLE)) st_d.int_en = cfg_wdata[0];
        if (clr_req) st_d.stat = 1'b0;
        if (set_req) st_d.stat = 1'b1;
        if (viol) begin
            st_d.stat = 1'b1;
            if (!st_q.stat) begin
                st_d.info_a = viol_addr;
                st_d.info_b = {viol_blk_bit, viol_nonsec, id16};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = 32'h0;
        if (cfg_addr == CFG_AW'(OFS_CTRL))   reg_rdata = {31'h0, st_q.mode};
        if (cfg_addr == CFG_AW'(OFS_STAT))   reg_rdata = {31'h0, st_q.stat};
        if (cfg_addr == CFG_AW'(OFS_ENABLE)) reg_rdata = {31'h0, st_q.int_en};
        if (cfg_addr == CFG_AW'(OFS_INFO_A)) reg_rdata = 32'(st_q.info_a);
        if (cfg_addr == CFG_AW'(OFS_INFO_B)) reg_rdata = 32'(st_q.info_b);
    end

    assign err_mode = (st_q.mode == RESP_ERROR);
    assign irq      = st_q.stat && st_q.int_en;

    // R6: first violation sets status and records its address
    p_first_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (viol && !st_q.stat) |=> (st_q.stat && st_q.info_a == $past(viol_addr)));

    // R7: records hold while status is set
    p_info_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stat |=> ($stable(st_q.info_a) && $stable(st_q.info_b)));

    // R9: set wins over clear in the same cycle
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req || viol) |=> st_q.stat);
endmodule

// File: rtl/mpc_filter.sv
module mpc_filter #(
    parameter int ADDR_W    = 16,
    parameter int BLK_SHIFT = 8,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 20,
    parameter int CFG_AW    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_nonsec,
    input  logic [ID_W-1:0]   req_id,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              cfg_en,
    input  logic              cfg_write,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              irq
);
    logic        blk_bit;
    logic        blocked;
    logic        err_mode;
    logic        tab_hit;
    logic [31:0] tab_word;
    logic [31:0] reg_word;

    mpc_table #(
        .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .CFG_AW(CFG_AW)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_en && cfg_write), .cfg_addr(cfg_addr), .wr_data(cfg_wdata),
        .cfg_hit(tab_hit), .cfg_word(tab_word),
        .look_addr(req_addr), .look_bit(blk_bit)
    );

    assign blocked = req_valid && (req_nonsec != blk_bit);

    mpc_status #(
        .ADDR_W(ADDR_W), .ID_W(ID_W), .CFG_AW(CFG_AW)
    ) u_status (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .reg_rdata(reg_word),
        .viol(blocked), .viol_addr(req_addr), .viol_nonsec(req_nonsec),
        .viol_id(req_id), .viol_blk_bit(blk_bit),
        .err_mode(err_mode), .irq(irq)
    );

    assign mem_valid = req_valid && !blocked;
    assign mem_write = req_write;
    assign mem_addr  = req_addr;
    assign mem_wdata = req_wdata;
    assign rsp_rdata = blocked ? '0 : mem_rdata;
    assign rsp_err   = blocked && err_mode;
    assign cfg_rdata = tab_hit ? tab_word : reg_word;

    // R3: mismatching transfer never reaches memory
    p_no_forward_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_nonsec != blk_bit) |-> !mem_valid);

    // R2: matching transfer is forwarded without error
    p_pass_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_nonsec == blk_bit) |-> (mem_valid && !rsp_err));

    // R4: zero-response mode returns zero and no error
    p_zero_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_nonsec != blk_bit && !err_mode) |-> (rsp_rdata == '0 && !rsp_err));

    // R5: error mode flags the blocked transfer
    p_err_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_nonsec != blk_bit && err_mode) |-> (rsp_err && rsp_rdata == '0));
endmodule

// File: tb/mpc_filter_tb.sv
module mpc_filter_tb;
    localparam int ADDR_W = 16, BLK_SHIFT = 8, DATA_W = 32, ID_W = 20, CFG_AW = 12;
    localparam int WORDS = ((1 << (ADDR_W - BLK_SHIFT)) + 31) / 32;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, req_nonsec = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [ID_W-1:0]   req_id = '0;
    logic [DATA_W-1:0] req_wdata = '0, mem_rdata = '0;
    logic [DATA_W-1:0] rsp_rdata, mem_wdata;
    logic rsp_err, mem_valid, mem_write, irq;
    logic [ADDR_W-1:0] mem_addr;
    logic cfg_en = 0, cfg_write = 0;
    logic [CFG_AW-1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0, cfg_rdata;

    int checks = 0, errors = 0;

    // bench model
    logic [31:0] m_tab [WORDS];
    logic m_mode = 0, m_en = 0, m_stat = 0;
    logic [31:0] m_info_a = 0, m_info_b = 0;

    always #10 clk = ~clk;

    mpc_filter #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .DATA_W(DATA_W),
                 .ID_W(ID_W), .CFG_AW(CFG_AW)) u_dut (.*);

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic model_bit(input logic [ADDR_W-1:0] a);
        int b = int'(a >> BLK_SHIFT);
        return m_tab[b / 32][b % 32];
    endfunction

    function automatic logic [31:0] model_read(input logic [CFG_AW-1:0] a);
        if (a == 12'h000) return {31'h0, m_mode};
        if (a == 12'h020) return {31'h0, m_stat};
        if (a == 12'h028) return {31'h0, m_en};
        if (a == 12'h02C) return m_info_a;
        if (a == 12'h030) return m_info_b;
        if (a >= 12'h100 && a < 12'h100 + 4 * WORDS && a[1:0] == 0)
            return m_tab[(a - 12'h100) >> 2];
        return 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = 0; cfg_en = 0; cfg_write = 0;
    endtask

    task automatic cfg_wr(input logic [CFG_AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        idle_inputs();
        cfg_en = 1; cfg_write = 1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1;
        if (a == 12'h000) m_mode = d[0];
        if (a == 12'h028) m_en = d[0];
        if (a == 12'h024 && d[0]) m_stat = 0;
        if (a == 12'h034 && d[0]) m_stat = 1;
        if (a >= 12'h100 && a < 12'h100 + 4 * WORDS) m_tab[(a - 12'h100) >> 2] = d;
    endtask

    task automatic cfg_chk(input string tag, input logic [CFG_AW-1:0] a);
        @(negedge clk);
        idle_inputs();
        cfg_en = 1; cfg_write = 0; cfg_addr = a;
        #2;
        check(tag, cfg_rdata, model_read(a));
        check({tag, " irq R10"}, {31'h0, irq}, {31'h0, m_stat & m_en});
    endtask

    task automatic xfer(input logic [ADDR_W-1:0] a, input logic ns, input logic wr,
                        input logic [ID_W-1:0] id, input string tag);
        logic blk, bb;
        logic [31:0] md;
        md = $urandom;
        bb = model_bit(a);
        blk = (ns != bb);
        @(negedge clk);
        idle_inputs();
        req_valid = 1; req_addr = a; req_nonsec = ns; req_write = wr; req_id = id;
        req_wdata = $urandom; mem_rdata = md;
        #2;
        check({tag, " mem_valid R2/R3"}, {31'h0, mem_valid}, {31'h0, !blk});
        check({tag, " rsp_err R4/R5"}, {31'h0, rsp_err}, {31'h0, blk & m_mode});
        check({tag, " rsp_rdata R2/R4"}, rsp_rdata, blk ? 32'h0 : md);
        if (!blk) check({tag, " fwd addr R2"}, {16'h0, mem_addr}, {16'h0, a});
        @(posedge clk);
        #1;
        if (blk) begin
            if (!m_stat) begin
                m_info_a = {16'h0, a};
                m_info_b = {14'h0, bb, ns, id[15:0]};
            end
            m_stat = 1;
        end
    endtask

    task automatic regs_chk(input string tag);
        cfg_chk({tag, " stat"}, 12'h020);
        cfg_chk({tag, " info_a"}, 12'h02C);
        cfg_chk({tag, " info_b"}, 12'h030);
    endtask

    initial begin
        void'($urandom(32'd4711));
        foreach (m_tab[i]) m_tab[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R11 reset values
        cfg_chk("R11 ctrl", 12'h000);
        regs_chk("R11");
        cfg_chk("R11 table0", 12'h100);
        check("R11 irq", {31'h0, irq}, 32'h0);

        // R1 directed: block 37 -> word 1 bit 5
        cfg_wr(12'h104, 32'h0000_0020);
        cfg_chk("R1 table readback", 12'h104);
        xfer(16'h2503, 1'b1, 1'b0, 20'hABCDE, "R1 block37 ns match");
        xfer(16'h2603, 1'b1, 1'b0, 20'h00001, "R1 block38 ns mismatch");
        // R6 first capture (zero mode, R4)
        regs_chk("R6 first capture");
        // R7 second violation does not overwrite
        xfer(16'h2510, 1'b0, 1'b1, 20'h12345, "R7 second violation write");
        regs_chk("R7 frozen");
        // R10 enable
        cfg_wr(12'h028, 32'h1);
        cfg_chk("R10 enable", 12'h028);
        // R8 clear and re-arm
        cfg_wr(12'h024, 32'h1);
        regs_chk("R8 cleared");
        xfer(16'h2520, 1'b0, 1'b0, 20'hFEDCB, "R8 rearm violation");
        regs_chk("R8 recaptured");
        // R9 forced set keeps info
        cfg_wr(12'h024, 32'h1);
        cfg_wr(12'h034, 32'h1);
        regs_chk("R9 forced set");
        cfg_wr(12'h024, 32'h1);
        // R5 error mode
        cfg_wr(12'h000, 32'h1);
        cfg_chk("R5 ctrl", 12'h000);
        xfer(16'h0042, 1'b1, 1'b0, 20'h00077, "R5 blocked read");
        xfer(16'h0042, 1'b1, 1'b1, 20'h00078, "R5 blocked write");
        xfer(16'h0042, 1'b0, 1'b0, 20'h00079, "R5 allowed read");
        regs_chk("R5 capture");

        // random table and traffic
        for (int w = 0; w < WORDS; w++) cfg_wr(12'(12'h100 + 4 * w), $urandom);
        for (int w = 0; w < WORDS; w++) cfg_chk("R1 random table", 12'(12'h100 + 4 * w));
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 9) == 0) cfg_wr(12'h024, 32'h1);
            if ($urandom_range(0, 19) == 0) cfg_wr(12'h000, {31'h0, 1'($urandom)});
            if ($urandom_range(0, 29) == 0) cfg_wr(12'h034, 32'h1);
            xfer(ADDR_W'($urandom), 1'($urandom), 1'($urandom), ID_W'($urandom),
                 "R2/R3/R6 random");
            if (n % 8 == 0) regs_chk("R6/R7/R8 random");
        end

        idle_inputs();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule